// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block holds the programming state of a four-channel DMA controller and exposes it through an 8-bit I/O port bus with a 4-bit port offset. Each channel keeps a 16-bit start address and a 16-bit transfer count. Each of these has a base copy and a current copy. Software reaches every 16-bit value as two byte accesses to a single port. A single byte-pointer flip-flop, shared by all the 16-bit ports, picks the byte. Around the channel registers sit a command register, a status register holding terminal-count flags, a per-channel mask and mode, and control ports that reset the pointer, clear or set masks, or perform a master clear. Channel numbers for the mask and mode ports travel inside the written data byte.

The transfer engine is outside this block. In its place, a step input advances one channel by one transfer. The step moves the current address up or down, decrements the current count and raises a terminal-count strobe when the count underflows. Software programs a count of N-1 to obtain N transfers. A channel in auto-initialise mode reloads its current registers from the base copies at terminal count.

Top module: `chanprog_regs`

## Requirements
- R1: After reset the byte pointer is low, all four mask bits are set, the command register and every mode field are zero, no terminal-count flag is set, and every address and count reads as zero.
- R2: Offset 2n is channel n's address port and offset 2n+1 its count port (n = 0..3). Each read or write of offsets 0x0-0x7 uses bits 7:0 when the pointer is low and bits 15:8 when it is high, then flips the pointer. A write loads that byte into both the base and current copies; a read returns the byte of the current copy.
- R3: Any write to offset 0xC puts the pointer in the low state, whatever the data.
- R4: A write to offset 0xA selects channel data[1:0] and sets its mask bit when data[2] is 1 and clears it when data[2] is 0; the other mask bits keep their values. mask_q bit n belongs to channel n.
- R5: A write to offset 0xF copies data[3:0] into the four mask bits; a write to offset 0xE clears all four mask bits whatever the data.
- R6: A write to offset 0xB selects channel data[1:0] and stores data[7:2] as that channel's 6-bit mode, visible at mode_q[6n+5:6n]. Other channels' modes are unchanged.
- R7: A write to offset 0x8 stores the byte in the command register (cmd_q). A read of offset 0x8 returns the terminal-count flags in bits 3:0 (bit n for channel n) and zeros in bits 7:4, and clears the flags after the read; a terminal count in the same cycle as the read stays flagged.
- R8: A step on an unmasked channel decrements its current count by one and changes its current address by one: upward, or downward when mode bit 3 (data bit 5 of the mode write) is set. A step on a masked channel changes nothing and raises no strobe.
- R9: A step on a channel whose current count is 0 is its terminal count: tc_strobe bit n is high during that step cycle and the channel's flag is set. Without auto-initialise the count wraps to 0xFFFF. With mode bit 2 (data bit 4) set, the current address and count reload from the base copies.
- R10: A write to offset 0xD (master clear) lowers the pointer, zeroes the command register, the modes and the flags, and sets all mask bits; addresses and counts keep their values.
- R11: Reads of offsets 0x9 to 0xF return 0x00, and reads or writes outside offsets 0x0-0x7 leave the pointer unchanged (except R3 and R10).
- R12: A step on a channel in the same cycle as a write to that channel's address or count port is dropped; only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_off | input | 4 | Port offset of the current access |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| xfer_step | input | 1 | Advance one channel by one transfer |
| xfer_chan | input | 2 | Channel to advance |
| tc_strobe | output | 4 | Terminal-count event, one bit per channel, during the step cycle |
| mask_q | output | 4 | Channel mask bits |
| cmd_q | output | 8 | Command register |
| mode_q | output | 24 | Six-bit mode per channel, channel n at bits 6n+5:6n |
| ptr_hi | output | 1 | Byte pointer state, 1 = high byte next |

## Verification
A wrong byte pointer shows up quickly. The next 16-bit read or write swaps its bytes, and ptr_hi differs one cycle after the access. A wrong current count or address inside a channel stays hidden until that register is read back or the channel reaches terminal count. For that reason the bench reads both halves of every register after each sweep, and it runs counts down to 0 to test the underflow cycle and the reload. Flag errors appear at the next status read, and a second read checks the clear-on-read. Mask and mode state is visible on the ports in the cycle after the write.

// File: rtl/chanprog_pkg.sv
package chanprog_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;
  localparam int MODE_W = 6;

  // Port offsets whose position other logic decodes
  localparam logic [3:0] OFF_CMD     = 4'h8;
  localparam logic [3:0] OFF_MASK1   = 4'hA;
  localparam logic [3:0] OFF_MODE    = 4'hB;
  localparam logic [3:0] OFF_FFCLR   = 4'hC;
  localparam logic [3:0] OFF_MCLR    = 4'hD;
  localparam logic [3:0] OFF_UNMASK  = 4'hE;
  localparam logic [3:0] OFF_MASKALL = 4'hF;

  // Bits inside the stored 6-bit mode field (data bits 7:2)
  localparam int MODE_AUTO_BIT = 2;
  localparam int MODE_DEC_BIT  = 3;

  function automatic logic [REG_W-1:0] merge_byte(input logic [REG_W-1:0] old,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic hi);
    logic [REG_W-1:0] r;
    r = old;
    if (hi) r[REG_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]     = b;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                  input logic hi);
    return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] next_addr(input logic [REG_W-1:0] a,
                                                 input logic dec);
    return dec ? a - REG_W'(1) : a + REG_W'(1);
  endfunction

  function automatic logic [REG_W-1:0] next_cnt(input logic [REG_W-1:0] c);
    return c - REG_W'(1);
  endfunction

  function automatic logic at_terminal(input logic [REG_W-1:0] c);
    return c == '0;
  endfunction
endpackage

// File: rtl/chanprog_decode.sv
module chanprog_decode import chanprog_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [3:0]        io_off,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              reg_hit,
  output logic [CH_W-1:0]   reg_ch,
  output logic              reg_is_cnt,
  output logic [NUM_CH-1:0] wr_addr_ch,
  output logic [NUM_CH-1:0] wr_cnt_ch,
  output logic              wr_cmd,
  output logic              wr_mask1,
  output logic              wr_mode,
  output logic              wr_ffclr,
  output logic              wr_mclr,
  output logic              wr_unmask,
  output logic              wr_maskall,
  output logic              rd_status,
  output logic              ptr_toggle
);
  localparam int REG_SPAN = 2 * NUM_CH;

  assign reg_hit    = 32'(io_off) < REG_SPAN;
  assign reg_ch     = io_off[CH_W:1];
  assign reg_is_cnt = io_off[0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign wr_addr_ch[n] = io_wr && reg_hit && (reg_ch == CH_W'(n)) && !reg_is_cnt;
    assign wr_cnt_ch[n]  = io_wr && reg_hit && (reg_ch == CH_W'(n)) &&  reg_is_cnt;
  end

  assign wr_cmd     = io_wr && (io_off == OFF_CMD);
  assign wr_mask1   = io_wr && (io_off == OFF_MASK1);
  assign wr_mode    = io_wr && (io_off == OFF_MODE);
  assign wr_ffclr   = io_wr && (io_off == OFF_FFCLR);
  assign wr_mclr    = io_wr && (io_off == OFF_MCLR);
  assign wr_unmask  = io_wr && (io_off == OFF_UNMASK);
  assign wr_maskall = io_wr && (io_off == OFF_MASKALL);
  assign rd_status  = io_rd && (io_off == OFF_CMD);
  assign ptr_toggle = (io_wr || io_rd) && reg_hit;
endmodule

// File: rtl/chanprog_chan.sv
module chanprog_chan import chanprog_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              step,
  input  logic              dec,
  input  logic              auto_init,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  cur_cnt,
  output logic              tc_evt
);
  logic [REG_W-1:0] base_addr, base_cnt;

  assign tc_evt = step && at_terminal(cur_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (wr_addr) begin
      base_addr <= merge_byte(base_addr, wdata, ptr_hi);
      cur_addr  <= merge_byte(cur_addr,  wdata, ptr_hi);
    end else if (wr_cnt) begin
      base_cnt  <= merge_byte(base_cnt, wdata, ptr_hi);
      cur_cnt   <= merge_byte(cur_cnt,  wdata, ptr_hi);
    end else if (step) begin
      if (tc_evt && auto_init) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= next_addr(cur_addr, dec);
        cur_cnt  <= next_cnt(cur_cnt);
      end
    end
  end
endmodule

// File: rtl/chanprog_ctrl.sv
module chanprog_ctrl import chanprog_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BYTE_W-1:0]        wdata,
  input  logic                     wr_cmd,
  input  logic                     wr_mask1,
  input  logic                     wr_mode,
  input  logic                     wr_ffclr,
  input  logic                     wr_mclr,
  input  logic                     wr_unmask,
  input  logic                     wr_maskall,
  input  logic                     rd_status,
  input  logic                     ptr_toggle,
  input  logic [NUM_CH-1:0]        tc_evt,
  output logic                     ptr_hi,
  output logic [NUM_CH-1:0]        mask_q,
  output logic [BYTE_W-1:0]        cmd_q,
  output logic [NUM_CH*MODE_W-1:0] mode_flat,
  output logic [NUM_CH-1:0]        tc_flags
);
  logic [CH_W-1:0] sel_ch;
  logic            sel_ok;
  logic [MODE_W-1:0] mode_r [NUM_CH];

  assign sel_ch = wdata[CH_W-1:0];
  assign sel_ok = 32'(sel_ch) < NUM_CH;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_mclr || wr_ffclr) ptr_hi <= 1'b0;
    else if (ptr_toggle)               ptr_hi <= !ptr_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_mclr)         mask_q <= '1;
    else if (wr_maskall)           mask_q <= wdata[NUM_CH-1:0];
    else if (wr_unmask)            mask_q <= '0;
    else if (wr_mask1 && sel_ok)   mask_q[sel_ch] <= wdata[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_mclr) cmd_q <= '0;
    else if (wr_cmd)       cmd_q <= wdata;
  end

  // Clear on status read, but a same-cycle terminal count survives
  always_ff @(posedge clk) begin
    if (!rst_n || wr_mclr) tc_flags <= '0;
    else tc_flags <= (rd_status ? '0 : tc_flags) | tc_evt;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n || wr_mclr)                    mode_r[n] <= '0;
      else if (wr_mode && sel_ch == CH_W'(n))   mode_r[n] <= wdata[BYTE_W-1:2];
    end
    assign mode_flat[n*MODE_W +: MODE_W] = mode_r[n];
  end
endmodule

// File: rtl/chanprog_regs.sv
module chanprog_regs import chanprog_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               io_off,
  input  logic [BYTE_W-1:0]        io_wdata,
  input  logic                     io_wr,
  input  logic                     io_rd,
  output logic [BYTE_W-1:0]        io_rdata,
  input  logic                     xfer_step,
  input  logic [CH_W-1:0]          xfer_chan,
  output logic [NUM_CH-1:0]        tc_strobe,
  output logic [NUM_CH-1:0]        mask_q,
  output logic [BYTE_W-1:0]        cmd_q,
  output logic [NUM_CH*MODE_W-1:0] mode_q,
  output logic                     ptr_hi
);
  logic              reg_hit, reg_is_cnt;
  logic [CH_W-1:0]   reg_ch;
  logic [NUM_CH-1:0] wr_addr_ch, wr_cnt_ch, step_ch;
  logic              wr_cmd, wr_mask1, wr_mode, wr_ffclr, wr_mclr;
  logic              wr_unmask, wr_maskall, rd_status, ptr_toggle;
  logic [NUM_CH-1:0] tc_flags;
  logic [NUM_CH*REG_W-1:0] cur_addr_flat, cur_cnt_flat;

  chanprog_decode #(.NUM_CH(NUM_CH)) dec_i (
    .io_off(io_off), .io_wr(io_wr), .io_rd(io_rd),
    .reg_hit(reg_hit), .reg_ch(reg_ch), .reg_is_cnt(reg_is_cnt),
    .wr_addr_ch(wr_addr_ch), .wr_cnt_ch(wr_cnt_ch),
    .wr_cmd(wr_cmd), .wr_mask1(wr_mask1), .wr_mode(wr_mode),
    .wr_ffclr(wr_ffclr), .wr_mclr(wr_mclr), .wr_unmask(wr_unmask),
    .wr_maskall(wr_maskall), .rd_status(rd_status), .ptr_toggle(ptr_toggle)
  );

  chanprog_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wdata(io_wdata),
    .wr_cmd(wr_cmd), .wr_mask1(wr_mask1), .wr_mode(wr_mode),
    .wr_ffclr(wr_ffclr), .wr_mclr(wr_mclr), .wr_unmask(wr_unmask),
    .wr_maskall(wr_maskall), .rd_status(rd_status), .ptr_toggle(ptr_toggle),
    .tc_evt(tc_strobe), .ptr_hi(ptr_hi), .mask_q(mask_q), .cmd_q(cmd_q),
    .mode_flat(mode_q), .tc_flags(tc_flags)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    // A step is dropped when masked or when the channel is being written
    assign step_ch[n] = xfer_step && (xfer_chan == CH_W'(n)) && !mask_q[n] &&
                        !wr_addr_ch[n] && !wr_cnt_ch[n];

    chanprog_chan chan_i (
      .clk(clk), .rst_n(rst_n), .ptr_hi(ptr_hi), .wdata(io_wdata),
      .wr_addr(wr_addr_ch[n]), .wr_cnt(wr_cnt_ch[n]), .step(step_ch[n]),
      .dec(mode_q[n*MODE_W + MODE_DEC_BIT]),
      .auto_init(mode_q[n*MODE_W + MODE_AUTO_BIT]),
      .cur_addr(cur_addr_flat[n*REG_W +: REG_W]),
      .cur_cnt(cur_cnt_flat[n*REG_W +: REG_W]),
      .tc_evt(tc_strobe[n])
    );
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (reg_hit)
        io_rdata = pick_byte(reg_is_cnt ? cur_cnt_flat[reg_ch*REG_W +: REG_W]
                                        : cur_addr_flat[reg_ch*REG_W +: REG_W],
                             ptr_hi);
      else if (rd_status)
        io_rdata = BYTE_W'(tc_flags);
    end
  end
endmodule

// File: rtl/chanprog_regs_chk.sv
module chanprog_regs_chk import chanprog_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [3:0]              io_off,
  input logic                    io_wr,
  input logic                    io_rd,
  input logic                    xfer_step,
  input logic [CH_W-1:0]         xfer_chan,
  input logic [NUM_CH-1:0]       tc_strobe,
  input logic [NUM_CH-1:0]       mask_q,
  input logic [BYTE_W-1:0]       cmd_q,
  input logic                    ptr_hi,
  input logic [NUM_CH-1:0]       tc_flags,
  input logic [NUM_CH*REG_W-1:0] cur_cnt_flat
);
  logic port_acc;
  assign port_acc = (io_wr || io_rd) && (32'(io_off) < 2 * NUM_CH);

  p_ptr_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    port_acc |=> ptr_hi != $past(ptr_hi));

  p_ffclr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_off == OFF_FFCLR) |=> !ptr_hi);

  p_unmask_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_off == OFF_UNMASK) |=> mask_q == '0);

  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_off == OFF_CMD && tc_strobe == '0) |=> tc_flags == '0);

  p_masked_no_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_step && mask_q[xfer_chan]) |-> tc_strobe == '0);

  p_tc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_strobe));

  p_tc_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tc_strobe) && !(io_wr && io_off == OFF_MCLR)) |=>
      ((tc_flags & $past(tc_strobe)) == $past(tc_strobe)));

  p_mclr_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_off == OFF_MCLR) |=>
      (mask_q == '1 && cmd_q == '0 && !ptr_hi && tc_flags == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_hold
    p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_step && xfer_chan == CH_W'(n) && mask_q[n] && !io_wr) |=>
        $stable(cur_cnt_flat[n*REG_W +: REG_W]));
  end
endmodule

bind chanprog_regs chanprog_regs_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_wr(io_wr), .io_rd(io_rd),
  .xfer_step(xfer_step), .xfer_chan(xfer_chan), .tc_strobe(tc_strobe),
  .mask_q(mask_q), .cmd_q(cmd_q), .ptr_hi(ptr_hi), .tc_flags(tc_flags),
  .cur_cnt_flat(cur_cnt_flat)
);

// File: tb/chanprog_regs_tb.sv
module chanprog_regs_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_off = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        xfer_step = 1'b0;
  logic [1:0]  xfer_chan = '0;
  logic [3:0]  tc_strobe, mask_q;
  logic [7:0]  cmd_q;
  logic [23:0] mode_q;
  logic        ptr_hi;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  chanprog_regs dut_i (
    .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .xfer_step(xfer_step), .xfer_chan(xfer_chan), .tc_strobe(tc_strobe),
    .mask_q(mask_q), .cmd_q(cmd_q), .mode_q(mode_q), .ptr_hi(ptr_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk); io_off = off; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] d);
    @(negedge clk); io_off = off; io_rd = 1'b1;
    #(CLK_P/4) d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] off, input logic [15:0] v);
    wr(4'hC, 8'h00);
    wr(off, v[7:0]);
    wr(off, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] off, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'hC, 8'h00);
    rd(off, lo);
    rd(off, hi);
    v = {hi, lo};
  endtask

  task automatic step(input logic [1:0] ch, output logic [3:0] tc);
    @(negedge clk); xfer_chan = ch; xfer_step = 1'b1;
    #(CLK_P/4) tc = tc_strobe;
    @(negedge clk); xfer_step = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    logic [15:0] v, ea, ec;
    logic [7:0]  b;
    logic [3:0]  tc, em;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ptr", ptr_hi, 0);
    chk("R1 mask", mask_q, 4'hF);
    chk("R1 cmd", cmd_q, 0);
    chk("R1 mode", mode_q, 0);
    rd(4'h8, b); chk("R1 status", b, 0);
    for (int c = 0; c < 4; c++) begin
      rd16(4'(2*c), v);   chk("R1 addr", v, 0);
      rd16(4'(2*c+1), v); chk("R1 count", v, 0);
    end

    // R2 pointer flip and sweep of every address and count port
    wr(4'hC, 8'h00);
    wr(4'h2, 8'h11);      chk("R2 ptr after one write", ptr_hi, 1);
    rd(4'h9, b);          chk("R11 ptr kept on other offset", ptr_hi, 1);
    chk("R11 read 0x9", b, 0);
    wr(4'hC, 8'hFF);      chk("R3 ptr cleared", ptr_hi, 0);
    for (int c = 0; c < 4; c++) begin
      wr16(4'(2*c),   16'(16'h1357 * (c + 1) + 16'h0A05));
      wr16(4'(2*c+1), 16'(~(16'h2468 * (c + 3))));
    end
    for (int c = 0; c < 4; c++) begin
      rd16(4'(2*c), v);   chk("R2 addr readback", v, 16'(16'h1357 * (c + 1) + 16'h0A05));
      rd16(4'(2*c+1), v); chk("R2 count readback", v, 16'(~(16'h2468 * (c + 3))));
    end

    // R4 single-channel mask
    wr(4'hE, 8'h00); chk("R5 clear mask", mask_q, 0);
    em = 4'h0;
    for (int c = 0; c < 4; c++) begin
      wr(4'hA, 8'(4 | c)); em[c] = 1'b1;
      chk("R4 set one", mask_q, em);
    end
    wr(4'hA, 8'h02); em[2] = 1'b0; chk("R4 clear one", mask_q, em);
    // R5 mask-all
    wr(4'hF, 8'h5A); chk("R5 mask all", mask_q, 4'hA);
    wr(4'hE, 8'hFF); chk("R5 unmask all", mask_q, 4'h0);

    // R6 mode per channel
    for (int c = 0; c < 4; c++) begin
      wr(4'hB, 8'((8'h44 + 8'(c * 8'h24)) | c));
    end
    for (int c = 0; c < 4; c++)
      chk("R6 mode field", mode_q[6*c +: 6], 6'(((8'h44 + 8'(c * 8'h24)) | c) >> 2));

    // R7 command
    wr(4'h8, 8'hA7); chk("R7 cmd", cmd_q, 8'hA7);

    // R8 increment, decrement and masked steps
    wr(4'hB, 8'h45);            // ch1: increment, no auto-init
    wr(4'hB, 8'h66);            // ch2: decrement (data bit 5)
    wr(4'hB, 8'h47);            // ch3
    wr16(4'h2, 16'h1000); wr16(4'h3, 16'h0003);
    wr16(4'h4, 16'h2000); wr16(4'h5, 16'h0010);
    step(2'd1, tc); chk("R8 no tc", tc, 0);
    step(2'd1, tc);
    rd16(4'h2, v); chk("R8 addr up", v, 16'h1002);
    rd16(4'h3, v); chk("R8 count down", v, 16'h0001);
    step(2'd2, tc);
    rd16(4'h4, v); chk("R8 addr down", v, 16'h1FFF);
    rd16(4'h5, v); chk("R8 count down dec", v, 16'h000F);
    wr(4'hA, 8'h07);
    rd16(4'h7, ec);
    step(2'd3, tc); chk("R8 masked no tc", tc, 0);
    rd16(4'h7, v); chk("R8 masked count", v, ec);

    // R9 terminal count with wrap
    step(2'd1, tc); chk("R9 count 1 no tc", tc, 0);
    step(2'd1, tc); chk("R9 tc strobe", tc, 4'h2);
    rd16(4'h3, v); chk("R9 wrap", v, 16'hFFFF);
    rd16(4'h2, v); chk("R9 addr past tc", v, 16'h1004);
    rd(4'h8, b); chk("R7 status flag", b, 8'h02);
    rd(4'h8, b); chk("R7 status cleared", b, 8'h00);

    // R9 auto-initialise reload
    wr(4'hB, 8'h54);            // ch0: auto-init (data bit 4)
    wr16(4'h0, 16'h0300); wr16(4'h1, 16'h0001);
    step(2'd0, tc);
    rd16(4'h0, v); chk("R9 auto addr step", v, 16'h0301);
    step(2'd0, tc); chk("R9 auto tc", tc, 4'h1);
    rd16(4'h0, v); chk("R9 auto addr reload", v, 16'h0300);
    rd16(4'h1, v); chk("R9 auto count reload", v, 16'h0001);

    // R7 same-cycle status read and terminal count
    rd(4'h8, b);
    wr16(4'h3, 16'h0000);
    @(negedge clk); io_off = 4'h8; io_rd = 1'b1; xfer_chan = 2'd1; xfer_step = 1'b1;
    #(CLK_P/4) b = io_rdata;
    @(negedge clk); io_rd = 1'b0; xfer_step = 1'b0;
    chk("R7 read before tc", b, 8'h00);
    rd(4'h8, b); chk("R7 tc kept", b, 8'h02);

    // R12 step dropped during a write to the same channel
    wr16(4'h5, 16'h0040);
    wr(4'hC, 8'h00);
    @(negedge clk); io_off = 4'h4; io_wdata = 8'h77; io_wr = 1'b1;
    xfer_chan = 2'd2; xfer_step = 1'b1;
    @(negedge clk); io_wr = 1'b0; xfer_step = 1'b0;
    rd16(4'h5, v); chk("R12 count kept", v, 16'h0040);
    rd16(4'h4, v); chk("R12 write applied", v, 16'h1F77);

    // R10 master clear
    wr(4'h8, 8'h3C);
    wr(4'hC, 8'h00); wr(4'h2, 8'h00);
    wr(4'hD, 8'h00);
    chk("R10 ptr", ptr_hi, 0);
    chk("R10 mask", mask_q, 4'hF);
    chk("R10 cmd", cmd_q, 0);
    chk("R10 mode", mode_q, 0);
    rd16(4'h2, v); chk("R10 addr kept", v, 16'h1000);
    rd16(4'h0, ea); chk("R10 ch0 addr kept", ea, 16'h0300);

    // R11 other read offsets
    for (int o = 9; o < 16; o++) begin
      rd(4'(o), b); chk("R11 zero read", b, 0);
    end
    summary();
  end
endmodule